// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block sits beside a memory and keeps a directory for a small number of memory blocks that are shared by several processor caches over a point-to-point network. The network has no broadcast. Each directory entry has one presence bit for each processor and a dirty flag. When the dirty flag is set, exactly one processor owns the block and is the only one allowed to write it back.

Caches send read-miss and write-permission requests. A read to a clean entry is answered at once and adds the reader as a sharer. A write is granted only after every other cache that holds a copy has been sent an invalidate and has acknowledged it. The grant then makes the writer the sole, dirty owner. A read to a block owned by another cache first asks the owner to write the block back, and then answers the reader and leaves both caches as clean sharers. Data contents are not modelled: a reply is a token naming the requester and the block.

The controller handles one transaction at a time. While it waits for acknowledgements or a write-back, it lowers its ready signal and new requests stay held at the sender.

Top module: `dirctl_top`

## Requirements
- R1: After reset, every entry is clean with no presence bit set, `reqReady` is 1, and all four message valids (`replyValid`, `grantValid`, `invValid`, `wbReqValid`) are 0.
- R2: A read request (`reqWrite`=0) to a clean entry produces a one-cycle `replyValid` in the cycle after acceptance, with `replyProc`/`replyBlock` equal to the requester and block. It sets the requester's presence bit and leaves the entry clean.
- R3: A write request (`reqWrite`=1) to an entry in which no processor other than the requester is present produces `grantValid` in the cycle after acceptance, with no invalidate.
- R4: A write request to an entry in which other processors are present produces a one-cycle `invValid` in the cycle after acceptance. `invMask` bit i is 1 exactly for each processor i other than the requester whose presence bit is set.
- R5: An acknowledgement counter is loaded with the number of invalidates sent. `grantValid` for that write appears in the cycle after the last outstanding acknowledgement is accepted, and never earlier.
- R6: An acknowledgement from a processor that is not awaited (never invalidated, or already counted) is ignored: it produces no message and does not advance the count.
- R7: After a write grant, the entry is dirty and only the writer's presence bit is set.
- R8: A read to an entry that is dirty and owned by another processor produces a one-cycle `wbReqValid` to that owner in the cycle after acceptance. Only the owner's acknowledgement completes it. The reply then follows in the next cycle, and the entry is left clean with both the owner and the reader present.
- R9: While a transaction waits for acknowledgements or a write-back, `reqReady` is 0 and an offered request is neither accepted nor changes the pending transaction.
- R10: A dirty entry always has exactly one presence bit set.
- R11: A read by the current owner of a dirty entry is replied to in the next cycle, and the entry stays dirty and owned.
- R12: At most one of the four message valids is high in any cycle, and each is a single-cycle pulse per transaction step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqProc | input | PROC_W | Requesting processor |
| reqBlock | input | BLK_W | Block index |
| reqWrite | input | 1 | 1 = write permission, 0 = read miss |
| ackValid | input | 1 | Acknowledgement (invalidate done or write-back done) |
| ackProc | input | PROC_W | Processor sending the acknowledgement |
| invValid | output | 1 | Invalidate messages issued |
| invMask | output | NUM_PROC | Processors to be invalidated |
| invBlock | output | BLK_W | Block being invalidated |
| wbReqValid | output | 1 | Write-back request issued |
| wbReqProc | output | PROC_W | Owner asked to write back |
| wbReqBlock | output | BLK_W | Block to write back |
| replyValid | output | 1 | Data reply token issued |
| replyProc | output | PROC_W | Reply destination |
| replyBlock | output | BLK_W | Replied block |
| grantValid | output | 1 | Write permission issued |
| grantProc | output | PROC_W | Grant destination |
| grantBlock | output | BLK_W | Granted block |

## Verification
The embedded properties check on every cycle that a dirty entry keeps a single presence bit, that the acknowledgement counter always matches the set of awaited caches, that a waiting transaction cannot finish while acknowledgements are still outstanding, that stray acknowledgements leave the count untouched, and that message valids never overlap. Only the bench's scenarios can show that the invalidate mask names exactly the right sharers, that the grant lands in the cycle after the final acknowledgement whatever order the acknowledgements arrive in, and that a write-back merges owner and reader into a clean sharer set. Those directory contents are made visible through the masks and owners named by later requests.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;

  // strobes from control to the directory datapath
  typedef struct packed {
    logic latchReq;   // capture requester and block
    logic addSharer;  // OR requester into presence of incoming block
    logic ownNow;     // requester becomes dirty owner (incoming block)
    logic ownLater;   // latched requester becomes dirty owner
    logic mergeBack;  // latched requester added, entry cleaned
  } dirStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_INV_WAIT = 2'd1,
    ST_WB_WAIT  = 2'd2
  } dirState_t;

endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dirctl_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int PROC_W     = $clog2(NUM_PROC),
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dirStrobe_t          strobe,
  input  logic [PROC_W-1:0]   reqProc,
  input  logic [BLK_W-1:0]    reqBlock,
  output logic [NUM_PROC-1:0] lookPres,
  output logic                lookDirty,
  output logic [PROC_W-1:0]   curProc,
  output logic [BLK_W-1:0]    curBlock
);

  localparam logic [NUM_PROC-1:0] ONE_BIT = NUM_PROC'(1);

  logic [NUM_PROC-1:0] presQ  [NUM_BLOCKS];
  logic                dirtyQ [NUM_BLOCKS];
  logic [NUM_PROC-1:0] inBit;
  logic [NUM_PROC-1:0] curBit;

  assign inBit     = ONE_BIT << reqProc;
  assign curBit    = ONE_BIT << curProc;
  assign lookPres  = presQ[reqBlock];
  assign lookDirty = dirtyQ[reqBlock];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curProc  <= '0;
      curBlock <= '0;
    end else if (strobe.latchReq) begin
      curProc  <= reqProc;
      curBlock <= reqBlock;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        presQ[b]  <= '0;
        dirtyQ[b] <= 1'b0;
      end
    end else begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        if (strobe.addSharer && reqBlock == BLK_W'(b)) begin
          presQ[b] <= presQ[b] | inBit;
        end
        if (strobe.ownNow && reqBlock == BLK_W'(b)) begin
          presQ[b]  <= inBit;
          dirtyQ[b] <= 1'b1;
        end
        if (strobe.ownLater && curBlock == BLK_W'(b)) begin
          presQ[b]  <= curBit;
          dirtyQ[b] <= 1'b1;
        end
        if (strobe.mergeBack && curBlock == BLK_W'(b)) begin
          presQ[b]  <= presQ[b] | curBit;
          dirtyQ[b] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_entryChk
    // R10
    single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
      dirtyQ[g] |-> ($countones(presQ[g]) == 1));
  end

endmodule

// File: rtl/dir_control.sv
module dir_control
  import dirctl_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int PROC_W   = $clog2(NUM_PROC),
  parameter int CNT_W    = $clog2(NUM_PROC + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [PROC_W-1:0]   reqProc,
  input  logic                reqWrite,
  input  logic [NUM_PROC-1:0] lookPres,
  input  logic                lookDirty,
  input  logic                ackValid,
  input  logic [PROC_W-1:0]   ackProc,
  output dirStrobe_t          strobe,
  output logic                reqReady,
  output logic                invValid,
  output logic [NUM_PROC-1:0] invMask,
  output logic                wbReqValid,
  output logic [PROC_W-1:0]   wbReqProc,
  output logic                replyValid,
  output logic                grantValid
);

  localparam logic [NUM_PROC-1:0] ONE_BIT = NUM_PROC'(1);

  dirState_t           st, stNext;
  logic [NUM_PROC-1:0] pendQ, pendNext;
  logic [CNT_W-1:0]    cntQ, cntNext;
  logic [NUM_PROC-1:0] others;
  logic                accept, ackHit;
  logic                fireReply, fireGrant, fireInv, fireWb;
  logic [PROC_W-1:0]   ownerIdx;

  function automatic logic [CNT_W-1:0] countOnes(input logic [NUM_PROC-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_PROC; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  assign others   = lookPres & ~(ONE_BIT << reqProc);
  assign reqReady = (st == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign ackHit   = ackValid && (st != ST_IDLE) && pendQ[ackProc];

  always_comb begin
    ownerIdx = '0;
    for (int i = NUM_PROC - 1; i >= 0; i--) begin
      if (others[i]) ownerIdx = PROC_W'(i);
    end
  end

  always_comb begin
    stNext    = st;
    pendNext  = pendQ;
    cntNext   = cntQ;
    strobe    = '0;
    fireReply = 1'b0;
    fireGrant = 1'b0;
    fireInv   = 1'b0;
    fireWb    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          strobe.latchReq = 1'b1;
          if (!reqWrite) begin
            if (lookDirty && others != '0) begin
              fireWb   = 1'b1;
              pendNext = others;
              cntNext  = CNT_W'(1);
              stNext   = ST_WB_WAIT;
            end else begin
              fireReply        = 1'b1;
              strobe.addSharer = 1'b1;
            end
          end else begin
            if (others == '0) begin
              fireGrant     = 1'b1;
              strobe.ownNow = 1'b1;
            end else begin
              fireInv  = 1'b1;
              pendNext = others;
              cntNext  = countOnes(others);
              stNext   = ST_INV_WAIT;
            end
          end
        end
      end
      ST_INV_WAIT: begin
        if (ackHit) begin
          pendNext = pendQ & ~(ONE_BIT << ackProc);
          cntNext  = cntQ - CNT_W'(1);
          if (cntQ == CNT_W'(1)) begin
            fireGrant       = 1'b1;
            strobe.ownLater = 1'b1;
            stNext          = ST_IDLE;
          end
        end
      end
      ST_WB_WAIT: begin
        if (ackHit) begin
          pendNext         = '0;
          cntNext          = '0;
          fireReply        = 1'b1;
          strobe.mergeBack = 1'b1;
          stNext           = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      pendQ      <= '0;
      cntQ       <= '0;
      invValid   <= 1'b0;
      invMask    <= '0;
      wbReqValid <= 1'b0;
      wbReqProc  <= '0;
      replyValid <= 1'b0;
      grantValid <= 1'b0;
    end else begin
      st         <= stNext;
      pendQ      <= pendNext;
      cntQ       <= cntNext;
      invValid   <= fireInv;
      invMask    <= fireInv ? others : '0;
      wbReqValid <= fireWb;
      if (fireWb) wbReqProc <= ownerIdx;
      replyValid <= fireReply;
      grantValid <= fireGrant;
    end
  end

  // R12
  msg_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({replyValid, grantValid, invValid, wbReqValid}));

  // R5
  ack_count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_INV_WAIT) |-> (int'(cntQ) == $countones(pendQ)));

  // R5
  hold_until_acks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_INV_WAIT && !ackHit) |=> (st == ST_INV_WAIT && !grantValid));

  // R6
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE && ackValid && !pendQ[ackProc]) |=> ($stable(cntQ) && $stable(pendQ)));

  // R8
  wb_single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WB_WAIT) |-> ($countones(pendQ) == 1));

  // R4
  inv_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invMask != '0));

endmodule

// File: rtl/dirctl_top.sv
module dirctl_top
  import dirctl_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int PROC_W     = $clog2(NUM_PROC),
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [PROC_W-1:0]   reqProc,
  input  logic [BLK_W-1:0]    reqBlock,
  input  logic                reqWrite,
  input  logic                ackValid,
  input  logic [PROC_W-1:0]   ackProc,
  output logic                invValid,
  output logic [NUM_PROC-1:0] invMask,
  output logic [BLK_W-1:0]    invBlock,
  output logic                wbReqValid,
  output logic [PROC_W-1:0]   wbReqProc,
  output logic [BLK_W-1:0]    wbReqBlock,
  output logic                replyValid,
  output logic [PROC_W-1:0]   replyProc,
  output logic [BLK_W-1:0]    replyBlock,
  output logic                grantValid,
  output logic [PROC_W-1:0]   grantProc,
  output logic [BLK_W-1:0]    grantBlock
);

  dirStrobe_t          strobe;
  logic [NUM_PROC-1:0] lookPres;
  logic                lookDirty;
  logic [PROC_W-1:0]   curProc;
  logic [BLK_W-1:0]    curBlock;

  dir_control #(.NUM_PROC(NUM_PROC), .PROC_W(PROC_W)) i_control (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqProc(reqProc), .reqWrite(reqWrite),
    .lookPres(lookPres), .lookDirty(lookDirty),
    .ackValid(ackValid), .ackProc(ackProc),
    .strobe(strobe), .reqReady(reqReady),
    .invValid(invValid), .invMask(invMask),
    .wbReqValid(wbReqValid), .wbReqProc(wbReqProc),
    .replyValid(replyValid), .grantValid(grantValid)
  );

  dir_datapath #(.NUM_PROC(NUM_PROC), .NUM_BLOCKS(NUM_BLOCKS),
                 .PROC_W(PROC_W), .BLK_W(BLK_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqProc(reqProc), .reqBlock(reqBlock),
    .lookPres(lookPres), .lookDirty(lookDirty),
    .curProc(curProc), .curBlock(curBlock)
  );

  assign invBlock   = curBlock;
  assign wbReqBlock = curBlock;
  assign replyProc  = curProc;
  assign replyBlock = curBlock;
  assign grantProc  = curProc;
  assign grantBlock = curBlock;

endmodule

// File: tb/test_dirctl_top.sv
module test_dirctl_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int PW = $clog2(NP);
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, ackValid = 1'b0;
  logic [PW-1:0] reqProc = '0, ackProc = '0;
  logic [BW-1:0] reqBlock = '0;
  logic reqReady, invValid, wbReqValid, replyValid, grantValid;
  logic [NP-1:0] invMask;
  logic [BW-1:0] invBlock, wbReqBlock, replyBlock, grantBlock;
  logic [PW-1:0] wbReqProc, replyProc, grantProc;

  int nChecks = 0;
  int nFail   = 0;

  logic [NP-1:0] mPres  [NB];
  logic          mDirty [NB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dirctl_top #(.NUM_PROC(NP), .NUM_BLOCKS(NB)) i_dirctl_top (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqProc(reqProc),
    .reqBlock(reqBlock), .reqWrite(reqWrite),
    .ackValid(ackValid), .ackProc(ackProc),
    .invValid(invValid), .invMask(invMask), .invBlock(invBlock),
    .wbReqValid(wbReqValid), .wbReqProc(wbReqProc), .wbReqBlock(wbReqBlock),
    .replyValid(replyValid), .replyProc(replyProc), .replyBlock(replyBlock),
    .grantValid(grantValid), .grantProc(grantProc), .grantBlock(grantBlock)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chkMsgs(input string tag, input logic r, input logic g,
                         input logic i, input logic w);
    chk(tag, "replyValid", 32'(replyValid), 32'(r));
    chk(tag, "grantValid", 32'(grantValid), 32'(g));
    chk(tag, "invValid",   32'(invValid),   32'(i));
    chk(tag, "wbReqValid", 32'(wbReqValid), 32'(w));
  endtask

  function automatic logic [NP-1:0] othersOf(input int p, input int b);
    return mPres[b] & ~(NP'(1) << p);
  endfunction

  function automatic int firstSet(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  // one acknowledgement cycle; returns at the negedge after the edge
  task automatic sendAck(input int p, input logic offerReq);
    ackValid = 1'b1;
    ackProc  = PW'(p);
    if (offerReq) begin
      reqValid = 1'b1;
      reqProc  = PW'($urandom % NP);
      reqBlock = BW'($urandom % NB);
      reqWrite = 1'(($urandom % 2));
      chk("R9", "reqReady while waiting", 32'(reqReady), 32'd0);
    end
    @(negedge clk);
    ackValid = 1'b0;
    reqValid = 1'b0;
  endtask

  task automatic doOp(input int p, input int b, input logic w);
    logic [NP-1:0] oth;
    oth = othersOf(p, b);
    @(negedge clk);
    chk("R9", "reqReady idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqProc  = PW'(p);
    reqBlock = BW'(b);
    reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    if (w) begin
      if (oth == '0) begin
        // R3 immediate grant
        chkMsgs("R3", 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3", "grantProc", 32'(grantProc), 32'(p));
        chk("R3", "grantBlock", 32'(grantBlock), 32'(b));
      end else begin
        int ord[NP];
        int n;
        logic [NP-1:0] pend;
        chkMsgs("R4", 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R4", "invMask", 32'(invMask), 32'(oth));
        chk("R4", "invBlock", 32'(invBlock), 32'(b));
        n = 0;
        for (int i = 0; i < NP; i++) if (oth[i]) begin ord[n] = i; n++; end
        for (int i = n - 1; i > 0; i--) begin
          int j = int'($urandom % (i + 1));
          int t = ord[i];
          ord[i] = ord[j];
          ord[j] = t;
        end
        pend = oth;
        for (int k = 0; k < n; k++) begin
          if ($urandom % 3 == 0) begin
            int s = int'($urandom % NP);
            if (!pend[s]) begin
              sendAck(s, ($urandom % 2) == 1);
              // R6 stray ack ignored, R12 inv was a single pulse
              chkMsgs("R6", 1'b0, 1'b0, 1'b0, 1'b0);
              chk("R6", "reqReady after stray ack", 32'(reqReady), 32'd0);
            end
          end
          sendAck(ord[k], k == 0);
          pend[ord[k]] = 1'b0;
          if (k == n - 1) begin
            // R5 grant right after last ack
            chkMsgs("R5", 1'b0, 1'b1, 1'b0, 1'b0);
            chk("R5", "grantProc", 32'(grantProc), 32'(p));
            chk("R5", "grantBlock", 32'(grantBlock), 32'(b));
          end else begin
            chkMsgs("R5", 1'b0, 1'b0, 1'b0, 1'b0);
          end
        end
      end
      mPres[b]  = NP'(1) << p;
      mDirty[b] = 1'b1;
    end else begin
      if (mDirty[b] && oth != '0) begin
        int own = firstSet(oth);
        chkMsgs("R8", 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8", "wbReqProc", 32'(wbReqProc), 32'(own));
        chk("R8", "wbReqBlock", 32'(wbReqBlock), 32'(b));
        if ($urandom % 2 == 0) begin
          sendAck((own + 1 + int'($urandom % (NP - 1))) % NP, 1'b1);
          chkMsgs("R6", 1'b0, 1'b0, 1'b0, 1'b0);
        end
        sendAck(own, 1'b0);
        chkMsgs("R8", 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8", "replyProc", 32'(replyProc), 32'(p));
        chk("R8", "replyBlock", 32'(replyBlock), 32'(b));
        mPres[b]  = mPres[b] | (NP'(1) << p);
        mDirty[b] = 1'b0;
      end else begin
        string tg = mDirty[b] ? "R11" : "R2";
        chkMsgs(tg, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(tg, "replyProc", 32'(replyProc), 32'(p));
        chk(tg, "replyBlock", 32'(replyBlock), 32'(b));
        mPres[b] = mPres[b] | (NP'(1) << p);
      end
    end
    @(negedge clk);
    // R12 every message is a single-cycle pulse
    chkMsgs("R12", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin mPres[b] = '0; mDirty[b] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reqReady", 32'(reqReady), 32'd1);
    chkMsgs("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reqReady after release", 32'(reqReady), 32'd1);
    // R1 empty directory: first write needs no invalidates
    doOp(0, 0, 1'b1);
    // R2 sharers build up, R4/R5/R6/R9 write with invalidates
    doOp(1, 2, 1'b0);
    doOp(2, 2, 1'b0);
    doOp(3, 2, 1'b0);
    doOp(3, 2, 1'b1);
    // R7 dirty owner 3: read by 0 needs write-back (R8)
    doOp(0, 2, 1'b0);
    // R8 clean with {0,3}: write by 1 invalidates exactly those
    doOp(1, 2, 1'b1);
    // R11 owner read keeps ownership; R3 owner write granted at once
    doOp(1, 2, 1'b0);
    doOp(1, 2, 1'b1);
    // R3 write by sole clean sharer
    doOp(2, 5, 1'b0);
    doOp(2, 5, 1'b1);
    // random mix over few blocks for contention
    for (int n = 0; n < 400; n++) begin
      doOp(int'($urandom % NP), int'($urandom % 3), 1'(($urandom % 2)));
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule